// File: doc/BRIEF.md
# Privilege-Aware Memory Protection Checker

This block decides, for every memory access, whether it may proceed. It keeps a small table of protection entries. Each entry holds an address register and an 8-bit configuration with read, write and execute grants, an address-match mode, a lock bit and a machine-only bit. The access port carries the address, the access kind and the current privilege. It also carries the load/store privilege redirect controls (redirect enable, redirect privilege) and the make-executable-readable control. The verdict is combinational from the registered table. Exactly one of three outputs is high: allow, an ordinary access fault, or a security violation.

A global isolation-mode flag selects between two interpretations of the table. With the flag clear, machine mode bypasses any entry that is neither locked nor machine-only. With the flag set, the table enforces a barrier between machine mode and the supervisor/user levels. Each region then belongs to one side or is explicitly shared. The lock bit only protects the entry from being rewritten. A machine-mode access that strays into supervisor/user territory is reported as a security violation rather than a fault. The flag can be set by software and stays set until reset.

Top module: `mem_prot_checker`

## Requirements
- R1: After reset every entry is off, its configuration is zero and the isolation flag is clear. An access that matches no entry is allowed at machine privilege (code 2'b11) and faults at user (2'b00) or supervisor (2'b01) privilege, in either mode.
- R2: For every access exactly one of `allow`, `fault` and `secViol` is high.
- R3: Configuration bits [4:3] select the match mode: 0 off, 1 top-of-range, 2 treated as off, 3 naturally aligned power-of-two. Address registers hold byte address bits [ADDR_W-1:2]. Top-of-range matches word addresses from the previous entry's register (zero for entry 0) up to but excluding its own. In power-of-two mode, k trailing ones in the register give a region of 2^(k+1) words.
- R4: When several entries match, the lowest-numbered one alone decides the verdict.
- R5: With the isolation flag clear, bit 0 grants read, bit 1 grants write and bit 2 grants execute. Access kinds are 2'b00 read, 2'b01 write and 2'b10 fetch, and 2'b11 counts as read. Supervisor and user accesses use the grants. Machine accesses get full access to an entry with bit 5 (machine-only) and bit 7 (lock) both clear. A lock bit of 1 subjects machine mode to the grants.
- R6: With the isolation flag clear and bit 5 set, the grants apply equally to all privilege levels, whatever the lock bit.
- R7: With the isolation flag set, the verdict depends on bit 5 and the grants, and not on the lock bit. Grants of 000 deny everyone. Grants of 010 give a shared read/write region when bit 5 is 0, and a shared execute-only region when bit 5 is 1. Any other grants give a supervisor/user-only region when bit 5 is 0, and a machine-only region when bit 5 is 1.
- R8: With the isolation flag set, a machine access that hits a supervisor/user-only region raises `secViol`. A machine access refused by a machine-only, shared or deny-all region raises `fault`. Supervisor or user accesses to a machine-only region raise `fault`.
- R9: A machine-mode read or write with the redirect enable set is judged at the redirect privilege, while fetches keep machine privilege. For a redirected read at supervisor/user level with make-executable-readable set, an execute grant also grants read. The control has no effect on accesses that are not redirected.
- R10: A configuration or address write to a locked entry is ignored. An address write to entry i is also ignored while entry i+1 is locked and in top-of-range mode. Writes to unlocked entries take effect on the next cycle, and bit 6 always reads zero.
- R11: A write of 1 to the isolation flag sets it. A write of 0 has no effect, and only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write `wrData[7:0]` into the configuration of entry `wrIdx` |
| addrWrEn | input | 1 | Write `wrData` into the address register of entry `wrIdx` |
| wrIdx | input | IDX_W | Entry selected for a table write |
| wrData | input | ADDR_W-2 | Write data (configuration in bits [7:0]) |
| mmlWrEn | input | 1 | Write strobe for the isolation flag |
| mmlWrVal | input | 1 | Value written to the isolation flag (only 1 acts) |
| accAddr | input | ADDR_W | Byte address of the access |
| accType | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| accPriv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| mprv | input | 1 | Redirect machine loads/stores to `mpp` privilege |
| mpp | input | 2 | Privilege used for redirected accesses |
| mxr | input | 1 | Execute grant also grants read on redirected reads |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Ordinary access fault |
| secViol | output | 1 | Machine access crossed the isolation barrier |

## Verification
The table and the isolation flag are the only state, and the verdict is a pure function of them. A corrupted configuration, address register or flag therefore shows at the ports on the first access that touches the affected region. That happens in the cycle after the bad write and needs no pipeline delay. A lock that fails to hold, or a flag that clears, shows up as a changed verdict on an access already known to have a fixed answer. A priority or range-boundary slip shows up on an access placed at an overlap or an edge. The reference model in the bench is advanced on every clock with the same writes and compared against all three outputs on every cycle. Any divergence in stored state is therefore caught at the first access that observes it.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_RSVD  = 2'd2,
    MATCH_NAPOT = 2'd3
  } matchMode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALTRD = 2'd3
  } accType_e;

  typedef enum logic [1:0] {
    V_ALLOW = 2'd0,
    V_FAULT = 2'd1,
    V_SECV  = 2'd2
  } verdict_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  // bit 7 lock, bit 6 reserved, bit 5 machine-only, bits 4:3 match mode, bits 2:0 XWR
  typedef struct packed {
    logic       lock;
    logic       rsvd;
    logic       mOnly;
    matchMode_e mode;
    logic       x;
    logic       w;
    logic       r;
  } entryCfg_t;

  // strobes from the write control to the register datapath
  typedef struct packed {
    logic cfgWe;
    logic addrWe;
    logic mmlSet;
  } regStrobe_t;

  function automatic verdict_e judgeEntry(entryCfg_t c, logic mml, logic isMachine,
                                          accType_e kind, logic mxrRead);
    logic       wantW;
    logic       wantX;
    logic       granted;
    logic [2:0] xwr;
    verdict_e   v;
    wantW   = (kind == ACC_WRITE);
    wantX   = (kind == ACC_FETCH);
    xwr     = {c.x, c.w, c.r};
    granted = wantX ? c.x : (wantW ? c.w : (c.r | (mxrRead & c.x)));
    if (!mml) begin
      if (isMachine && !c.mOnly && !c.lock) v = V_ALLOW;
      else                                  v = granted ? V_ALLOW : V_FAULT;
    end else if (xwr == 3'b000) begin
      v = V_FAULT;
    end else if (xwr == 3'b010) begin
      if (c.mOnly) v = wantX ? V_ALLOW : V_FAULT;
      else         v = wantX ? V_FAULT : V_ALLOW;
    end else if (!c.mOnly) begin
      if (isMachine) v = V_SECV;
      else           v = granted ? V_ALLOW : V_FAULT;
    end else begin
      if (!isMachine) v = V_FAULT;
      else            v = granted ? V_ALLOW : V_FAULT;
    end
    return v;
  endfunction

endpackage

// File: rtl/mpc_wrctl.sv
module mpc_wrctl
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 cfgWrEn,
  input  logic                 addrWrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 mmlWrEn,
  input  logic                 mmlWrVal,
  input  logic [N_ENTRIES-1:0] lockVec,
  input  logic [N_ENTRIES-1:0] torVec,
  output regStrobe_t           stb
);

  logic [N_ENTRIES-1:0] addrProt;
  logic                 cfgBlock;
  logic                 addrBlock;

  // an address register is also guarded by a locked top-of-range successor
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_prot
    if (i == N_ENTRIES - 1) begin : g_last
      assign addrProt[i] = lockVec[i];
    end else begin : g_mid
      assign addrProt[i] = lockVec[i] | (lockVec[i+1] & torVec[i+1]);
    end
  end

  // index outside the table blocks the write
  always_comb begin
    cfgBlock  = 1'b1;
    addrBlock = 1'b1;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (wrIdx == IDX_W'(i)) begin
        cfgBlock  = lockVec[i];
        addrBlock = addrProt[i];
      end
    end
  end

  always_comb begin
    stb.cfgWe  = cfgWrEn & ~cfgBlock;
    stb.addrWe = addrWrEn & ~addrBlock;
    stb.mmlSet = mmlWrEn & mmlWrVal;
  end

endmodule

// File: rtl/mpc_regfile.sv
module mpc_regfile
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3,
  parameter int PW        = 30,
  parameter bit HAS_MBIT  = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    stb,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic [PW-1:0]                 wrData,
  output entryCfg_t [N_ENTRIES-1:0]     cfgQ,
  output logic [N_ENTRIES-1:0][PW-1:0]  addrQ,
  output logic                          mmlQ
);

  // bit 6 never stored; bit 5 stored only when the machine-only bit exists
  localparam logic [7:0] CFG_KEEP = HAS_MBIT ? 8'hBF : 8'h9F;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        cfgQ[i]  <= '0;
        addrQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (stb.cfgWe && wrIdx == IDX_W'(i)) cfgQ[i] <= entryCfg_t'(wrData[7:0] & CFG_KEEP);
        if (stb.addrWe && wrIdx == IDX_W'(i)) addrQ[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           mmlQ <= 1'b0;
    else if (stb.mmlSet) mmlQ <= 1'b1;
  end

  AST_MML_STICKY: assert property (@(posedge clk) disable iff (!rstN) mmlQ |=> mmlQ); // R11

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_chk
    AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      cfgQ[i].lock |=> $stable(cfgQ[i])); // R10
    AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      cfgQ[i].lock |=> $stable(addrQ[i])); // R10
    if (i > 0) begin : g_tor
      AST_TOR_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (cfgQ[i].lock && cfgQ[i].mode == MATCH_TOR) |=> $stable(addrQ[i-1])); // R10
    end
  end

endmodule

// File: rtl/mpc_match.sv
module mpc_match
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 32,
  parameter int PW        = 30
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  entryCfg_t [N_ENTRIES-1:0]     cfgQ,
  input  logic [N_ENTRIES-1:0][PW-1:0]  addrQ,
  input  logic                          mmlQ,
  input  logic [ADDR_W-1:0]             accAddr,
  input  logic [1:0]                    accType,
  input  logic [1:0]                    accPriv,
  input  logic                          mprv,
  input  logic [1:0]                    mpp,
  input  logic                          mxr,
  output logic                          allow,
  output logic                          fault,
  output logic                          secViol
);

  logic [PW-1:0]        wordAddr;
  logic [N_ENTRIES-1:0] hit;
  logic                 anyHit;
  entryCfg_t            selCfg;
  logic                 redirect;
  logic [1:0]           effPriv;
  logic                 isMachine;
  logic                 mxrRead;
  accType_e             kind;
  verdict_e             verdict;
  logic                 unusedLowBits;
  logic [N_ENTRIES-1:0] unusedRsvd;

  assign wordAddr      = accAddr[ADDR_W-1:2];
  assign unusedLowBits = ^accAddr[1:0];
  assign kind          = accType_e'(accType);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_hit
    logic [PW-1:0] lowBound;
    logic [PW-1:0] napotMask;
    if (i == 0) begin : g_first
      assign lowBound = '0;
    end else begin : g_rest
      assign lowBound = addrQ[i-1];
    end
    assign napotMask     = ~(addrQ[i] ^ (addrQ[i] + PW'(1)));
    assign unusedRsvd[i] = cfgQ[i].rsvd;
    always_comb begin
      case (cfgQ[i].mode)
        MATCH_TOR:   hit[i] = (wordAddr >= lowBound) && (wordAddr < addrQ[i]);
        MATCH_NAPOT: hit[i] = ((wordAddr ^ addrQ[i]) & napotMask) == '0;
        default:     hit[i] = 1'b0;
      endcase
    end
  end

  // scan downward so the lowest matching index is the last to assign
  always_comb begin
    selCfg = '0;
    anyHit = 1'b0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        selCfg = cfgQ[i];
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    redirect  = (accPriv == PRIV_MACHINE) && mprv && (kind != ACC_FETCH);
    effPriv   = redirect ? mpp : accPriv;
    isMachine = (effPriv == PRIV_MACHINE);
    mxrRead   = redirect && !isMachine && mxr && (kind != ACC_WRITE) && (kind != ACC_FETCH);
    if (anyHit) verdict = judgeEntry(selCfg, mmlQ, isMachine, kind, mxrRead);
    else        verdict = isMachine ? V_ALLOW : V_FAULT;
  end

  assign allow   = (verdict == V_ALLOW);
  assign fault   = (verdict == V_FAULT);
  assign secViol = (verdict == V_SECV);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({allow, fault, secViol})); // R2
  AST_SECV_NEEDS_MML: assert property (@(posedge clk) disable iff (!rstN)
    secViol |-> (mmlQ && isMachine && anyHit)); // R8
  AST_NO_HIT_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !anyHit |-> (allow == isMachine)); // R1
  AST_FETCH_KEEPS_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    (kind == ACC_FETCH && accPriv == PRIV_MACHINE && !anyHit) |-> allow); // R9

endmodule

// File: rtl/mem_prot_checker.sv
module mem_prot_checker
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 32,
  parameter bit HAS_MBIT  = 1'b1,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int PW       = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              addrWrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PW-1:0]     wrData,
  input  logic              mmlWrEn,
  input  logic              mmlWrVal,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accType,
  input  logic [1:0]        accPriv,
  input  logic              mprv,
  input  logic [1:0]        mpp,
  input  logic              mxr,
  output logic              allow,
  output logic              fault,
  output logic              secViol
);

  regStrobe_t                   stb;
  entryCfg_t [N_ENTRIES-1:0]    cfgQ;
  logic [N_ENTRIES-1:0][PW-1:0] addrQ;
  logic                         mmlQ;
  logic [N_ENTRIES-1:0]         lockVec;
  logic [N_ENTRIES-1:0]         torVec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_flags
    assign lockVec[i] = cfgQ[i].lock;
    assign torVec[i]  = (cfgQ[i].mode == MATCH_TOR);
  end

  mpc_wrctl #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_wrctl (
    .cfgWrEn (cfgWrEn),
    .addrWrEn(addrWrEn),
    .wrIdx   (wrIdx),
    .mmlWrEn (mmlWrEn),
    .mmlWrVal(mmlWrVal),
    .lockVec (lockVec),
    .torVec  (torVec),
    .stb     (stb)
  );

  mpc_regfile #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .PW(PW), .HAS_MBIT(HAS_MBIT)) u_regfile (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrIdx (wrIdx),
    .wrData(wrData),
    .cfgQ  (cfgQ),
    .addrQ (addrQ),
    .mmlQ  (mmlQ)
  );

  mpc_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .PW(PW)) u_match (
    .clk    (clk),
    .rstN   (rstN),
    .cfgQ   (cfgQ),
    .addrQ  (addrQ),
    .mmlQ   (mmlQ),
    .accAddr(accAddr),
    .accType(accType),
    .accPriv(accPriv),
    .mprv   (mprv),
    .mpp    (mpp),
    .mxr    (mxr),
    .allow  (allow),
    .fault  (fault),
    .secViol(secViol)
  );

endmodule

// File: tb/mem_prot_checker_bench.sv
`timescale 1ns/1ps
module mem_prot_checker_bench;

  localparam int VA = 0;  // allow
  localparam int VF = 1;  // fault
  localparam int VS = 2;  // security violation
  localparam logic [1:0] TR = 2'b00, TW = 2'b01, TX = 2'b10;
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        addrWrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [29:0] wrData = '0;
  logic        mmlWrEn = 1'b0;
  logic        mmlWrVal = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accType = '0;
  logic [1:0]  accPriv = '0;
  logic        mprv = 1'b0;
  logic [1:0]  mpp = '0;
  logic        mxr = 1'b0;
  logic        allow;
  logic        fault;
  logic        secViol;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mem_prot_checker u_mem_prot_checker (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .addrWrEn(addrWrEn), .wrIdx(wrIdx),
    .wrData(wrData), .mmlWrEn(mmlWrEn), .mmlWrVal(mmlWrVal), .accAddr(accAddr),
    .accType(accType), .accPriv(accPriv), .mprv(mprv), .mpp(mpp), .mxr(mxr),
    .allow(allow), .fault(fault), .secViol(secViol)
  );

  // reference state
  logic [7:0]  refCfg  [8];
  logic [29:0] refAddr [8];
  bit          refMml;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < 8; e++) begin
        refCfg[e]  <= 8'h00;
        refAddr[e] <= '0;
      end
      refMml <= 1'b0;
    end else begin
      if (cfgWrEn && !refCfg[wrIdx][7]) refCfg[wrIdx] <= wrData[7:0] & 8'hBF;
      if (addrWrEn && !refCfg[wrIdx][7] &&
          !(wrIdx < 7 && refCfg[wrIdx+1][7] && refCfg[wrIdx+1][4:3] == 2'd1))
        refAddr[wrIdx] <= wrData;
      if (mmlWrEn && mmlWrVal) refMml <= 1'b1;
    end
  end

  function automatic bit inRegion(int e, logic [29:0] w);
    int     ones;
    longint span;
    longint lo;
    if (refCfg[e][4:3] == 2'd1) begin
      lo = (e == 0) ? 0 : longint'(refAddr[e-1]);
      return (longint'(w) >= lo) && (longint'(w) < longint'(refAddr[e]));
    end
    if (refCfg[e][4:3] == 2'd3) begin
      ones = 0;
      while (ones < 30 && refAddr[e][ones]) ones++;
      span = longint'(1) << (ones + 1);
      return (longint'(w) / span) == (longint'(refAddr[e]) / span);
    end
    return 1'b0;
  endfunction

  function automatic int refVerdict(logic [31:0] a, logic [1:0] t, logic [1:0] p,
                                    logic mp, logic [1:0] pp, logic mx);
    int         found;
    bit         redir;
    bit         machine;
    bit         need;
    logic [7:0] c;
    found   = -1;
    redir   = (p == PM) && mp && (t != TX);
    machine = ((redir ? pp : p) == PM);
    for (int e = 7; e >= 0; e--) if (inRegion(e, a[31:2])) found = e;
    if (found < 0) return machine ? VA : VF;
    c = refCfg[found];
    if (t == TX)      need = c[2];
    else if (t == TW) need = c[1];
    else              need = c[0] || (redir && !machine && mx && c[2]);
    if (!refMml) begin
      if (machine && !c[5] && !c[7]) return VA;
      return need ? VA : VF;
    end
    if (c[2:0] == 3'b000) return VF;
    if (c[2:0] == 3'b010) return c[5] ? ((t == TX) ? VA : VF) : ((t == TX) ? VF : VA);
    if (!c[5]) return machine ? VS : (need ? VA : VF);
    return machine ? (need ? VA : VF) : VF;
  endfunction

  function automatic int seen();
    if ($countones({allow, fault, secViol}) != 1) return 9;
    return allow ? VA : (fault ? VF : VS);
  endfunction

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (seen() != refVerdict(accAddr, accType, accPriv, mprv, mpp, mxr)) begin
        errors++;
        $display("FAIL R2 per-cycle model at %0t: got %0d expected %0d", $time, seen(),
                 refVerdict(accAddr, accType, accPriv, mprv, mpp, mxr));
      end
    end
  end

  task automatic wrCfg(input int idx, input logic [7:0] v);
    wrIdx = 3'(idx); wrData = {22'd0, v}; cfgWrEn = 1'b1;
    @(posedge clk); #1 cfgWrEn = 1'b0;
  endtask

  task automatic wrAddr(input int idx, input logic [29:0] v);
    wrIdx = 3'(idx); wrData = v; addrWrEn = 1'b1;
    @(posedge clk); #1 addrWrEn = 1'b0;
  endtask

  task automatic wrMml(input logic v);
    mmlWrVal = v; mmlWrEn = 1'b1;
    @(posedge clk); #1 mmlWrEn = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] t, input logic [1:0] p,
                       input logic mp, input logic [1:0] pp, input logic mx,
                       input int exp, input string tag);
    accAddr = a; accType = t; accPriv = p; mprv = mp; mpp = pp; mxr = mx;
    @(negedge clk);
    checks++;
    if (seen() != exp) begin
      errors++;
      $display("FAIL %s addr %h: got %0d expected %0d", tag, a, seen(), exp);
    end
    #1;
  endtask

  task automatic pulseReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;
  endtask

  initial begin
    #50000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rstN = 1'b1;

    // reset state and no-match default
    probe(32'h1000, TR, PM, 0, PU, 0, VA, "R1 reset M");
    probe(32'h1000, TR, PU, 0, PU, 0, VF, "R1 reset U");
    probe(32'h1000, TR, PS, 0, PU, 0, VF, "R1 reset S");

    // entry 0: top-of-range up to 0x1000, read only
    wrAddr(0, 30'h400); wrCfg(0, 8'h09);
    probe(32'h0FFC, TR, PU, 0, PU, 0, VA, "R3 tor last word");
    probe(32'h0000, TR, PU, 0, PU, 0, VA, "R3 tor base zero");
    probe(32'h1000, TR, PU, 0, PU, 0, VF, "R3 tor top excluded");
    probe(32'h0FFC, TW, PU, 0, PU, 0, VF, "R5 user write no grant");
    probe(32'h0FFC, TW, PM, 0, PU, 0, VA, "R5 machine bypass unlocked");

    // entry 1: 256-byte power-of-two region at 0x2000, read/write
    wrAddr(1, 30'h81F); wrCfg(1, 8'h1B);
    probe(32'h20F0, TW, PU, 0, PU, 0, VA, "R3 napot inside");
    probe(32'h2100, TW, PU, 0, PU, 0, VF, "R3 napot past end");
    probe(32'h1FFC, TR, PU, 0, PU, 0, VF, "R3 napot before start");
    probe(32'h20F0, TX, PU, 0, PU, 0, VF, "R5 user fetch no grant");

    // entry 3: 4 KiB region at 0x2000, all grants; overlaps entry 1
    wrAddr(3, 30'h9FF); wrCfg(3, 8'h1F);
    probe(32'h2010, TX, PU, 0, PU, 0, VF, "R4 lower entry wins");
    probe(32'h2200, TX, PU, 0, PU, 0, VA, "R4 higher entry only");

    // entry 2: reserved mode 2 acts as off
    wrAddr(2, 30'hC00); wrCfg(2, 8'h17);
    probe(32'h3004, TR, PU, 0, PU, 0, VF, "R3 mode two off");

    // lock entry 0
    wrCfg(0, 8'h89);
    probe(32'h0FFC, TW, PM, 0, PU, 0, VF, "R5 locked binds machine");
    probe(32'h0FFC, TR, PM, 0, PU, 0, VA, "R5 locked machine read");
    wrCfg(0, 8'h0F);
    probe(32'h0FFC, TW, PM, 0, PU, 0, VF, "R10 locked cfg write ignored");
    probe(32'h0FFC, TW, PU, 0, PU, 0, VF, "R10 locked cfg user");
    wrAddr(0, 30'h800);
    probe(32'h1800, TR, PU, 0, PU, 0, VF, "R10 locked addr write ignored");
    probe(32'h0FFC, TR, PU, 0, PU, 0, VA, "R10 locked addr kept");

    // entries 4/5: locked top-of-range guards the base register
    wrAddr(4, 30'h1400); wrAddr(5, 30'h1800); wrCfg(5, 8'h8C);
    probe(32'h5800, TX, PU, 0, PU, 0, VA, "R3 tor inside");
    probe(32'h4FFC, TX, PU, 0, PU, 0, VF, "R3 tor below base");
    wrAddr(4, 30'h1000);
    probe(32'h4FFC, TX, PU, 0, PU, 0, VF, "R10 base addr protected");
    probe(32'h5000, TX, PU, 0, PU, 0, VA, "R10 base addr unchanged");
    wrCfg(4, 8'h19);
    probe(32'h5004, TR, PU, 0, PU, 0, VA, "R10 unlocked cfg accepted");
    probe(32'h5004, TX, PU, 0, PU, 0, VF, "R4 entry four decides");

    // entry 6: machine-only bit in legacy mode, read only
    wrAddr(6, 30'h1C1F); wrCfg(6, 8'h39);
    probe(32'h7010, TW, PM, 0, PU, 0, VF, "R6 machine bound unlocked");
    probe(32'h7010, TR, PM, 0, PU, 0, VA, "R6 machine read");
    probe(32'h7010, TR, PU, 0, PU, 0, VA, "R6 user read");
    probe(32'h7010, TX, PS, 0, PU, 0, VF, "R6 super fetch");

    // redirect and make-executable-readable in legacy mode
    probe(32'h9000, TR, PM, 0, PU, 0, VA, "R9 no redirect");
    probe(32'h9000, TR, PM, 1, PU, 0, VF, "R9 redirect to user");
    probe(32'h9000, TX, PM, 1, PU, 0, VA, "R9 fetch not redirected");
    probe(32'h9000, TW, PM, 1, PM, 0, VA, "R9 redirect to machine");
    probe(32'h5800, TR, PM, 1, PU, 0, VF, "R9 exec-only read");
    probe(32'h5800, TR, PM, 1, PU, 1, VA, "R9 mxr grants read");
    probe(32'h5800, TR, PU, 0, PU, 1, VF, "R9 mxr needs redirect");

    // isolation mode
    wrMml(1'b1);
    probe(32'h0FFC, TR, PM, 0, PU, 0, VS, "R8 machine into user region");
    probe(32'h0FFC, TR, PU, 0, PU, 0, VA, "R7 user region read");
    probe(32'h0FFC, TW, PU, 0, PU, 0, VF, "R7 user region write");
    probe(32'h2010, TR, PM, 0, PU, 0, VS, "R8 machine into user rw");
    probe(32'h5800, TX, PM, 0, PU, 0, VS, "R8 machine fetch user code");
    probe(32'h5800, TX, PU, 0, PU, 0, VA, "R7 user fetch");
    probe(32'h5800, TR, PM, 1, PS, 1, VA, "R9 mxr under isolation");
    probe(32'h5800, TR, PM, 1, PS, 0, VF, "R9 no mxr under isolation");
    probe(32'h7010, TR, PM, 0, PU, 0, VA, "R7 machine-only read");
    probe(32'h7010, TW, PM, 0, PU, 0, VF, "R8 machine-only refused");
    probe(32'h7010, TR, PU, 0, PU, 0, VF, "R8 user on machine-only");

    wrAddr(7, 30'h201F); wrCfg(7, 8'h1A);
    probe(32'h8010, TW, PM, 0, PU, 0, VA, "R7 shared rw machine");
    probe(32'h8010, TR, PU, 0, PU, 0, VA, "R7 shared rw user");
    probe(32'h8010, TX, PM, 0, PU, 0, VF, "R8 shared rw fetch");
    wrCfg(7, 8'h3A);
    probe(32'h8010, TX, PM, 0, PU, 0, VA, "R7 shared exec machine");
    probe(32'h8010, TX, PU, 0, PU, 0, VA, "R7 shared exec user");
    probe(32'h8010, TW, PU, 0, PU, 0, VF, "R7 shared exec write");
    probe(32'h8010, TR, PM, 0, PU, 0, VF, "R8 shared exec read");

    wrCfg(2, 8'h18);
    probe(32'h3004, TR, PM, 0, PU, 0, VF, "R7 deny-all machine");
    probe(32'h3004, TR, PU, 0, PU, 0, VF, "R7 deny-all user");

    wrMml(1'b0);
    probe(32'h0FFC, TR, PM, 0, PU, 0, VS, "R11 flag sticky");
    probe(32'h9000, TR, PM, 0, PU, 0, VA, "R1 no match machine");
    probe(32'h9000, TR, PU, 0, PU, 0, VF, "R1 no match user");

    pulseReset();
    probe(32'h0FFC, TR, PM, 0, PU, 0, VA, "R11 reset clears flag");
    probe(32'h0FFC, TW, PU, 0, PU, 0, VF, "R1 table cleared");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule